// File: doc/BRIEF.md
# Accelerator Port Interface Queues

This block sits between a scalar in-order pipeline and a spatial compute array. It holds a bank of input queues and a bank of output queues, one queue per port. Each bank has its own 5-bit port number space. The pipeline pushes operands into input queues with a send. One send may carry two operands, and each operand names its own input port. The pipeline pulls results out of output queues with a receive. A receive takes one value from one named output port and hands it to writeback with a destination register tag.

A value that comes from a memory load uses the same send path as a value read from the register file. A value bound for a store uses the same receive path as one bound for a register. On a receive, one flag picks which writeback strobe fires. The array side of every queue is a plain valid/ready pair. Queues never drop data. A send that cannot fit, or a receive from an empty queue, raises a stall, and the pipeline presents the same instruction again on the next cycle. A stalled instruction changes no state, so the retry is always safe.

Top module: `accel_port_queues`

## Requirements
- R1: After reset every input queue is empty (`arr_in_valid` all 0) and every output queue is empty with space (`arr_out_ready` all 1). No writeback strobe is high, and `stall` is low while no request is presented.
- R2: A send with `snd_b_vld`=0 enqueues only `snd_data_a` into input queue `snd_port_a`. It shows at the array side of that port on the next cycle. `snd_data_b` is discarded, and a later receive from that port after loopback finds only one value.
- R3: A send with `snd_b_vld`=1 and two different port numbers enqueues `snd_data_a` into queue `snd_port_a` and `snd_data_b` into queue `snd_port_b` in the same cycle.
- R4: When both operands of a two-value send name the same port, that queue takes `snd_data_a` first and `snd_data_b` second. The send needs two free entries and stalls while fewer are free.
- R5: While a targeted input queue is full, `stall` is high in the same cycle and nothing is enqueued. The send completes in the first cycle after the array has drained an entry. No queue ever holds more than DEPTH values.
- R6: A two-value send whose second target queue is full enqueues neither value, even if the first target has space.
- R7: A receive accepted in cycle n (`rcv_en`=1, `stall`=0) drives, in cycle n+1, a one-cycle writeback strobe with the head value of output queue `rcv_port` on `wb_data` and `rcv_tag` on `wb_tag`.
- R8: A receive from an empty output queue holds `stall` high and fires no writeback. Once the array has pushed a value into that queue, the receive completes in the next cycle.
- R9: `rcv_to_mem`=1 routes the result to `wb_mem_en`, and `rcv_to_mem`=0 routes it to `wb_rf_en`. The two strobes are never high together.
- R10: Each output queue returns values in arrival order. When it holds DEPTH values its `arr_out_ready` is low and the array keeps the next value waiting.
- R11: Queues of different port numbers are independent. Values sent to one port never appear at another.
- R12: A send and a receive presented in the same cycle complete together or stall together. If either one stalls, neither changes any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_en | input | 1 | Send request |
| snd_port_a | input | AW | Input port for the first operand |
| snd_data_a | input | DW | First operand |
| snd_b_vld | input | 1 | Second operand present |
| snd_port_b | input | AW | Input port for the second operand |
| snd_data_b | input | DW | Second operand |
| rcv_en | input | 1 | Receive request |
| rcv_port | input | AW | Output port to dequeue |
| rcv_tag | input | RW | Destination register tag |
| rcv_to_mem | input | 1 | 1: result goes to memory, 0: to the register file |
| stall | output | 1 | Current request cannot complete this cycle |
| wb_rf_en | output | 1 | Register-file writeback strobe |
| wb_mem_en | output | 1 | Memory-store strobe |
| wb_data | output | DW | Received value |
| wb_tag | output | RW | Tag of the received value |
| arr_in_valid | output | 2**AW | Input queue holds data, per port |
| arr_in_data | output | 2**AW*DW | Input queue heads, port p at bits p*DW upward |
| arr_in_ready | input | 2**AW | Array takes the input queue head, per port |
| arr_out_valid | input | 2**AW | Array offers a result, per port |
| arr_out_data | input | 2**AW*DW | Array results, port p at bits p*DW upward |
| arr_out_ready | output | 2**AW | Output queue has space, per port |

## Verification
The checker watches four things on every cycle. No queue ever exceeds DEPTH. A receive from an empty queue always stalls. Every accepted receive, and only an accepted receive, yields exactly one writeback strobe with its own tag, and the memory and register strobes are never high together. Other behaviours can only be shown by the directed scenarios, because each needs a known sequence of sends and drains. These are the ordering of two same-port operands, send atomicity when one target is full, exact capacity at one and two free entries, and in-order return across a full output queue. So are the discard of the unused second operand and the joint stall of a combined send and receive.

// File: rtl/aqb_pkg.sv
package aqb_pkg;
    localparam int unsigned AQB_ADDR_W  = 5;
    localparam int unsigned AQB_DATA_W  = 64;
    localparam int unsigned AQB_DEPTH   = 4;

    // pointer width for a ring of the given depth
    function automatic int unsigned ptr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/aqb_fifo.sv
module aqb_fifo
    import aqb_pkg::*;
#(
    parameter int unsigned DW    = AQB_DATA_W,
    parameter int unsigned DEPTH = AQB_DEPTH,
    localparam int unsigned PW   = ptr_width(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push0,
    input  logic [DW-1:0] d0,
    input  logic          push1,
    input  logic [DW-1:0] d1,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [PW-1:0] wp_v;
    logic          pop_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        pop_ok = pop && (st_q.cnt != '0);
        if (pop_ok) begin
            st_d.rp = step(st_q.rp);
        end
        wp_v = st_q.wp;
        if (push0) begin
            st_d.mem[wp_v] = d0;
            wp_v           = step(wp_v);
        end
        if (push1) begin
            st_d.mem[wp_v] = d1;
            wp_v           = step(wp_v);
        end
        st_d.wp  = wp_v;
        st_d.cnt = st_q.cnt + CW'(push0) + CW'(push1) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/aqb_issue.sv
module aqb_issue
    import aqb_pkg::*;
#(
    parameter int unsigned AW    = AQB_ADDR_W,
    parameter int unsigned DEPTH = AQB_DEPTH,
    localparam int unsigned NP   = 1 << AW,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                   snd_en,
    input  logic [AW-1:0]          a_port,
    input  logic                   b_vld,
    input  logic [AW-1:0]          b_port,
    input  logic                   rcv_en,
    input  logic [AW-1:0]          rcv_port,
    input  logic [NP-1:0][CW-1:0]  in_cnt,
    input  logic [NP-1:0][CW-1:0]  out_cnt,
    output logic                   stall,
    output logic [NP-1:0]          in_push0,
    output logic [NP-1:0]          in_sel_b,
    output logic [NP-1:0]          in_push1,
    output logic [NP-1:0]          out_pop
);
    logic          same_port;
    logic [CW:0]   need;
    logic          blk_a, blk_b, snd_blk, rcv_blk, go;

    always_comb begin
        same_port = b_vld && (a_port == b_port);
        need      = same_port ? (CW+1)'(2) : (CW+1)'(1);
        blk_a     = ((CW+1)'(in_cnt[a_port]) + need) > (CW+1)'(DEPTH);
        blk_b     = b_vld && !same_port && (in_cnt[b_port] == CW'(DEPTH));
        snd_blk   = snd_en && (blk_a || blk_b);
        rcv_blk   = rcv_en && (out_cnt[rcv_port] == '0);
        stall     = snd_blk || rcv_blk;
        go        = !stall;
        for (int i = 0; i < NP; i++) begin
            in_push0[i] = go && snd_en &&
                          ((a_port == AW'(i)) || (b_vld && (b_port == AW'(i))));
            in_sel_b[i] = (a_port != AW'(i));
            in_push1[i] = go && snd_en && same_port && (a_port == AW'(i));
            out_pop[i]  = go && rcv_en && (rcv_port == AW'(i));
        end
    end
endmodule

// File: rtl/accel_port_queues.sv
module accel_port_queues
    import aqb_pkg::*;
#(
    parameter int unsigned AW    = AQB_ADDR_W,
    parameter int unsigned RW    = 5,
    parameter int unsigned DW    = AQB_DATA_W,
    parameter int unsigned DEPTH = AQB_DEPTH,
    localparam int unsigned NP   = 1 << AW,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snd_en,
    input  logic [AW-1:0]    snd_port_a,
    input  logic [DW-1:0]    snd_data_a,
    input  logic             snd_b_vld,
    input  logic [AW-1:0]    snd_port_b,
    input  logic [DW-1:0]    snd_data_b,
    input  logic             rcv_en,
    input  logic [AW-1:0]    rcv_port,
    input  logic [RW-1:0]    rcv_tag,
    input  logic             rcv_to_mem,
    output logic             stall,
    output logic             wb_rf_en,
    output logic             wb_mem_en,
    output logic [DW-1:0]    wb_data,
    output logic [RW-1:0]    wb_tag,
    output logic [NP-1:0]    arr_in_valid,
    output logic [NP*DW-1:0] arr_in_data,
    input  logic [NP-1:0]    arr_in_ready,
    input  logic [NP-1:0]    arr_out_valid,
    input  logic [NP*DW-1:0] arr_out_data,
    output logic [NP-1:0]    arr_out_ready
);
    typedef struct packed {
        logic          vld;
        logic          to_mem;
        logic [RW-1:0] tag;
        logic [DW-1:0] data;
    } result_t;

    logic [NP-1:0][CW-1:0] in_cnt, out_cnt;
    logic [NP-1:0][DW-1:0] in_head, out_head;
    logic [NP-1:0]         in_push0, in_sel_b, in_push1, out_pop;
    result_t               res_d, res_q;

    aqb_issue #(.AW(AW), .DEPTH(DEPTH)) u_issue (
        .snd_en   (snd_en),
        .a_port   (snd_port_a),
        .b_vld    (snd_b_vld),
        .b_port   (snd_port_b),
        .rcv_en   (rcv_en),
        .rcv_port (rcv_port),
        .in_cnt   (in_cnt),
        .out_cnt  (out_cnt),
        .stall    (stall),
        .in_push0 (in_push0),
        .in_sel_b (in_sel_b),
        .in_push1 (in_push1),
        .out_pop  (out_pop)
    );

    for (genvar g = 0; g < NP; g++) begin : g_port
        aqb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push0 (in_push0[g]),
            .d0    (in_sel_b[g] ? snd_data_b : snd_data_a),
            .push1 (in_push1[g]),
            .d1    (snd_data_b),
            .pop   (arr_in_ready[g] && arr_in_valid[g]),
            .head  (in_head[g]),
            .count (in_cnt[g])
        );
        assign arr_in_valid[g]           = (in_cnt[g] != '0);
        assign arr_in_data[g*DW +: DW]   = in_head[g];

        aqb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push0 (arr_out_valid[g] && arr_out_ready[g]),
            .d0    (arr_out_data[g*DW +: DW]),
            .push1 (1'b0),
            .d1    ('0),
            .pop   (out_pop[g]),
            .head  (out_head[g]),
            .count (out_cnt[g])
        );
        assign arr_out_ready[g] = (out_cnt[g] != CW'(DEPTH));
    end

    always_comb begin
        res_d        = res_q;
        res_d.vld    = rcv_en && !stall;
        res_d.to_mem = rcv_to_mem;
        res_d.tag    = rcv_tag;
        res_d.data   = out_head[rcv_port];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign wb_rf_en  = res_q.vld && !res_q.to_mem;
    assign wb_mem_en = res_q.vld &&  res_q.to_mem;
    assign wb_data   = res_q.data;
    assign wb_tag    = res_q.tag;
endmodule

// File: rtl/aqb_checker.sv
module aqb_checker #(
    parameter int unsigned AW    = 5,
    parameter int unsigned RW    = 5,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned NP   = 1 << AW,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  stall,
    input logic                  rcv_en,
    input logic [AW-1:0]         rcv_port,
    input logic [RW-1:0]         rcv_tag,
    input logic                  wb_rf_en,
    input logic                  wb_mem_en,
    input logic [RW-1:0]         wb_tag,
    input logic [NP-1:0][CW-1:0] in_cnt,
    input logic [NP-1:0][CW-1:0] out_cnt
);
    logic over;
    always_comb begin
        over = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (in_cnt[i] > CW'(DEPTH) || out_cnt[i] > CW'(DEPTH)) over = 1'b1;
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n) !over);
    p_empty_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_en && out_cnt[rcv_port] == '0) |-> stall);
    p_wb_follows_rcv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_en && !stall) |=> (wb_rf_en || wb_mem_en));
    p_tag_carried_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_en && !stall) |=> (wb_tag == $past(rcv_tag)));
    p_no_spurious_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rcv_en && !stall) |=> !(wb_rf_en || wb_mem_en));
    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_rf_en && wb_mem_en));
endmodule

bind accel_port_queues aqb_checker #(.AW(AW), .RW(RW), .DEPTH(DEPTH)) u_aqb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .rcv_en    (rcv_en),
    .rcv_port  (rcv_port),
    .rcv_tag   (rcv_tag),
    .wb_rf_en  (wb_rf_en),
    .wb_mem_en (wb_mem_en),
    .wb_tag    (wb_tag),
    .in_cnt    (in_cnt),
    .out_cnt   (out_cnt)
);

// File: tb/test_accel_port_queues.sv
`timescale 1ns/1ps
module test_accel_port_queues;
    localparam int AW = 5, RW = 5, DW = 64, DEPTH = 4;
    localparam int NP = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snd_en = 0, snd_b_vld = 0, rcv_en = 0, rcv_to_mem = 0;
    logic [AW-1:0] snd_port_a = '0, snd_port_b = '0, rcv_port = '0;
    logic [DW-1:0] snd_data_a = '0, snd_data_b = '0;
    logic [RW-1:0] rcv_tag = '0;
    logic stall, wb_rf_en, wb_mem_en;
    logic [DW-1:0] wb_data;
    logic [RW-1:0] wb_tag;
    logic [NP-1:0] arr_in_valid, arr_in_ready, arr_out_valid, arr_out_ready;
    logic [NP*DW-1:0] arr_in_data, arr_out_data;
    logic loop_en = 1'b0;

    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // array stand-in: input port p loops back to output port p
    always_comb begin
        arr_out_valid = arr_in_valid & {NP{loop_en}};
        arr_out_data  = arr_in_data;
        arr_in_ready  = arr_out_ready & {NP{loop_en}};
    end

    accel_port_queues #(.AW(AW), .RW(RW), .DW(DW), .DEPTH(DEPTH)) i_accel_port_queues (
        .clk(clk), .rst_n(rst_n),
        .snd_en(snd_en), .snd_port_a(snd_port_a), .snd_data_a(snd_data_a),
        .snd_b_vld(snd_b_vld), .snd_port_b(snd_port_b), .snd_data_b(snd_data_b),
        .rcv_en(rcv_en), .rcv_port(rcv_port), .rcv_tag(rcv_tag), .rcv_to_mem(rcv_to_mem),
        .stall(stall), .wb_rf_en(wb_rf_en), .wb_mem_en(wb_mem_en),
        .wb_data(wb_data), .wb_tag(wb_tag),
        .arr_in_valid(arr_in_valid), .arr_in_data(arr_in_data), .arr_in_ready(arr_in_ready),
        .arr_out_valid(arr_out_valid), .arr_out_data(arr_out_data), .arr_out_ready(arr_out_ready)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] in_head(input int p);
        return arr_in_data[p*DW +: DW];
    endfunction

    // present one instruction slot mid-cycle, clock it, return the stall seen
    task automatic issue(input logic se, input int a, input logic [DW-1:0] da,
                         input logic bv, input int b, input logic [DW-1:0] db,
                         input logic re, input int rp, input int rt, input logic rm,
                         output logic st);
        snd_en = se; snd_port_a = AW'(a); snd_data_a = da;
        snd_b_vld = bv; snd_port_b = AW'(b); snd_data_b = db;
        rcv_en = re; rcv_port = AW'(rp); rcv_tag = RW'(rt); rcv_to_mem = rm;
        #1 st = stall;
        @(posedge clk); #2;
        snd_en = 0; snd_b_vld = 0; rcv_en = 0; rcv_to_mem = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic send1(input int a, input logic [DW-1:0] da, output logic st);
        issue(1, a, da, 0, a, ~da, 0, 0, 0, 0, st);
    endtask

    task automatic send2(input int a, input logic [DW-1:0] da,
                         input int b, input logic [DW-1:0] db, output logic st);
        issue(1, a, da, 1, b, db, 0, 0, 0, 0, st);
    endtask

    task automatic recv_wait(input int p, input int tag, input logic mem,
                             output logic [DW-1:0] d, output int tries);
        logic st;
        tries = 0;
        for (int k = 0; k < 20; k++) begin
            issue(0, 0, 0, 0, 0, 0, 1, p, tag, mem, st);
            if (!st) break;
            tries++;
        end
        d = wb_data;
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "stall", DW'(stall), 0);
        chk("R1", "arr_in_valid", DW'(arr_in_valid), 0);
        chk("R1", "arr_out_ready", DW'(arr_out_ready), DW'({NP{1'b1}}));
        chk("R1", "wb strobes", DW'({wb_rf_en, wb_mem_en}), 0);
    endtask

    task automatic t_single();
        logic st; logic [DW-1:0] d; int tr;
        send1(3, 64'hA1, st);
        chk("R2", "stall", DW'(st), 0);
        chk("R2", "valid port3", DW'(arr_in_valid[3]), 1);
        chk("R2", "head port3", in_head(3), 64'hA1);
        loop_en = 1; idle(1); loop_en = 0;
        recv_wait(3, 7, 0, d, tr);
        chk("R7", "data", d, 64'hA1);
        chk("R7", "tag", DW'(wb_tag), 7);
        chk("R7", "rf strobe", DW'(wb_rf_en), 1);
        issue(0, 0, 0, 0, 0, 0, 1, 3, 7, 0, st);
        chk("R2", "second value dropped -> stall", DW'(st), 1);
        chk("R8", "no wb on stalled recv", DW'({wb_rf_en, wb_mem_en}), 0);
    endtask

    task automatic t_dual();
        logic st; logic [DW-1:0] d; int tr;
        send2(1, 64'hD1, 2, 64'hD2, st);
        chk("R3", "stall", DW'(st), 0);
        chk("R3", "head port1", in_head(1), 64'hD1);
        chk("R3", "head port2", in_head(2), 64'hD2);
        loop_en = 1; idle(1); loop_en = 0;
        recv_wait(2, 2, 0, d, tr);
        chk("R11", "port2 data", d, 64'hD2);
        recv_wait(1, 1, 0, d, tr);
        chk("R11", "port1 data", d, 64'hD1);
    endtask

    task automatic t_same_port();
        logic st; logic [DW-1:0] d; int tr;
        send2(4, 64'h41, 4, 64'h42, st);
        chk("R4", "stall", DW'(st), 0);
        chk("R4", "head first operand", in_head(4), 64'h41);
        loop_en = 1; idle(2); loop_en = 0;
        recv_wait(4, 4, 0, d, tr);
        chk("R4", "first out", d, 64'h41);
        recv_wait(4, 4, 0, d, tr);
        chk("R4", "second out", d, 64'h42);
    endtask

    task automatic t_full();
        logic st; logic [DW-1:0] d; int tr;
        for (int i = 0; i < DEPTH; i++) begin
            send1(5, 64'h50 + DW'(i), st);
            chk("R5", "fill stall", DW'(st), 0);
        end
        send1(5, 64'h54, st);
        chk("R5", "full stall", DW'(st), 1);
        chk("R5", "head unchanged", in_head(5), 64'h50);
        loop_en = 1;
        tr = 0;
        for (int k = 0; k < 10; k++) begin
            send1(5, 64'h54, st);
            if (!st) break;
            tr++;
        end
        chk("R5", "stalled retries before drain", DW'(tr), 1);
        idle(6);
        chk("R10", "out ready low when full", DW'(arr_out_ready[5]), 0);
        chk("R10", "fifth value waits", DW'(arr_in_valid[5]), 1);
        for (int i = 0; i <= DEPTH; i++) begin
            recv_wait(5, i, 0, d, tr);
            chk("R10", "in-order value", d, 64'h50 + DW'(i));
        end
        loop_en = 0;
    endtask

    task automatic t_atomic();
        logic st;
        for (int i = 0; i < DEPTH; i++) send1(6, 64'h60 + DW'(i), st);
        send2(7, 64'h70, 6, 64'h71, st);
        chk("R6", "stall", DW'(st), 1);
        chk("R6", "first target untouched", DW'(arr_in_valid[7]), 0);
        chk("R6", "full queue head", in_head(6), 64'h60);
        for (int i = 0; i < DEPTH-1; i++) send1(8, 64'h80 + DW'(i), st);
        send2(8, 64'h88, 8, 64'h89, st);
        chk("R4", "same-port needs two entries", DW'(st), 1);
        send1(8, 64'h88, st);
        chk("R4", "one entry fits", DW'(st), 0);
    endtask

    task automatic t_joint();
        logic st;
        issue(1, 21, 64'h21, 0, 21, 0, 1, 22, 5, 0, st);
        chk("R12", "stall", DW'(st), 1);
        chk("R12", "send held", DW'(arr_in_valid[21]), 0);
        chk("R12", "no wb", DW'({wb_rf_en, wb_mem_en}), 0);
    endtask

    task automatic t_empty();
        logic st; logic [DW-1:0] d; int tr;
        for (int k = 0; k < 2; k++) begin
            issue(0, 0, 0, 0, 0, 0, 1, 20, 9, 0, st);
            chk("R8", "empty stall", DW'(st), 1);
            chk("R8", "no wb", DW'({wb_rf_en, wb_mem_en}), 0);
        end
        loop_en = 1;
        send1(20, 64'h2020, st);
        recv_wait(20, 9, 0, d, tr);
        chk("R8", "stalls until arrival", DW'(tr), 1);
        chk("R8", "data", d, 64'h2020);
    endtask

    task automatic t_mem();
        logic st; logic [DW-1:0] d; int tr;
        send1(9, 64'h9999, st);
        idle(1);
        recv_wait(9, 3, 1, d, tr);
        chk("R9", "mem strobe", DW'(wb_mem_en), 1);
        chk("R9", "rf strobe", DW'(wb_rf_en), 0);
        chk("R9", "data", d, 64'h9999);
        chk("R9", "tag", DW'(wb_tag), 3);
        idle(1);
        chk("R7", "strobe one cycle", DW'({wb_rf_en, wb_mem_en}), 0);
        loop_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
        t_reset();
        t_single();
        t_dual();
        t_same_port();
        t_full();
        t_atomic();
        t_joint();
        t_empty();
        t_mem();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule